// File: doc/BRIEF.md
# Wait-State Peripheral Bus Master

This block connects a processor core to a small external parallel bus on which up to eight peripheral registers sit in the core's address space. The core raises a request with a register index, a direction flag and, for stores, a data word. The block then runs one bus access. It presents the register index and the direction line for one setup cycle. It then pulls the active-low enable strobe and holds it until the addressed peripheral answers with its active-low ready input.

During a store the block drives its data word onto the bus only while the strobe is low. During a load it captures the bus word on the clock edge where ready is seen low. Either way it reports completion with a one-cycle done pulse. A peripheral that never answers is cut off by a watchdog after a parameterised number of strobe cycles, and that completion carries an error flag. The bidirectional data pins are split into output, output-enable and input so that the pad ring can combine them.

Top module: `pbus_master`

## Requirements
- R1: In reset and in the cycle after reset is applied: pb_en_n=1, pb_dout_oe=0, rsp_done=0, rsp_err=0, busy=0. After reset rsp_rdata=0.
- R2: An edge that samples req_valid=1 with busy=0 accepts the request. In the next cycle busy=1, pb_addr and pb_rd_wn carry the request, and pb_en_n is still 1 (setup). pb_en_n goes low in the cycle after that.
- R3: pb_addr and pb_rd_wn do not change while pb_en_n is low, nor in the cycle in which it returns high.
- R4: pb_rd_wn is 1 for a load (req_write=0) and 0 for a store (req_write=1).
- R5: For a store, pb_dout_oe is 1 exactly in the cycles in which pb_en_n is 0, and pb_dout equals the request's data word. For a load, pb_dout_oe stays 0.
- R6: pb_rdy_n is sampled on rising clock edges. Every edge that sees it high (not ready) extends the strobe by a cycle. The strobe rises in the cycle after the first edge that sees it low, so a peripheral that answers after W cycles gives a strobe of W+1 cycles.
- R7: A load stores the pb_din word sampled on the ready edge into rsp_rdata. rsp_done is high for exactly one cycle, the cycle in which pb_en_n returns high, with busy=0. rsp_rdata holds its value across stores.
- R8: A request raised while busy=1 is dropped: it starts no access and changes no peripheral register.
- R9: If ready stays high, the strobe ends after TIMEOUT_CYCLES (default 256) low cycles with rsp_done=1 and rsp_err=1, and rsp_rdata is left unchanged.
- R10: rsp_err is 0 on every completion that ends by ready, and is never 1 without rsp_done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Core requests an access |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W (3) | Peripheral register index |
| req_wdata | input | DATA_W (16) | Store data |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Completion ended by the watchdog |
| rsp_rdata | output | DATA_W (16) | Last loaded word |
| busy | output | 1 | An access is in progress |
| pb_addr | output | ADDR_W (3) | Bus register index |
| pb_rd_wn | output | 1 | Bus direction, 1 = read, 0 = write |
| pb_en_n | output | 1 | Access strobe, active low |
| pb_rdy_n | input | 1 | Peripheral ready, active low |
| pb_dout | output | DATA_W (16) | Data toward the bus |
| pb_dout_oe | output | 1 | Drive enable for pb_dout |
| pb_din | input | DATA_W (16) | Data from the bus |

## Verification
The bench varies the ready delay from zero to nine cycles and counts the strobe length each time. A design that samples ready one edge late, or that ends the strobe before seeing it, shows up as an off-by-one length or as a load that captures the filler word the bench drives outside a live read. It raises a store request in the middle of a stretched load and then reads the target register back, which catches a block that queues or half-starts the second access. It also holds ready high until the watchdog fires, which exposes a timer that is off by one or that clobbers the last loaded word, and it resets the block in the middle of a strobe, which exposes a data driver left enabled.

// File: rtl/pbus_pkg.sv
package pbus_pkg;
   typedef enum logic [1:0] {
      PB_IDLE   = 2'd0,
      PB_SETUP  = 2'd1,
      PB_STROBE = 2'd2
   } pb_state_e;
endpackage

// File: rtl/pbus_wdog.sv
module pbus_wdog #(
   parameter int LIMIT = 256
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic tick,
   output logic expired
);
   if (LIMIT == 0) begin : g_off
      logic unused_w;
      assign unused_w = ^{clk, rst_n, clear, tick};
      assign expired  = 1'b0;
   end else begin : g_on
      localparam int CNT_W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
      localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);
      logic [CNT_W-1:0] cnt_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cnt_q <= '0;
         end else if (clear) begin
            cnt_q <= '0;
         end else if (tick && (cnt_q != LAST)) begin
            cnt_q <= cnt_q + 1'b1;
         end
      end

      assign expired = (cnt_q == LAST);
   end
endmodule

// File: rtl/pbus_seq.sv
module pbus_seq
   import pbus_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      req_valid,
   input  logic      rdy_n,
   input  logic      expired,
   output pb_state_e state_q,
   output logic      accept,
   output logic      finish_ok,
   output logic      strobe_next,
   output logic      wdog_clear,
   output logic      wdog_tick,
   output logic      en_n_q,
   output logic      done_q,
   output logic      err_q
);
   pb_state_e state_d;
   logic      finish_to;

   assign accept    = (state_q == PB_IDLE) && req_valid;
   assign finish_ok = (state_q == PB_STROBE) && !rdy_n;
   assign finish_to = (state_q == PB_STROBE) && rdy_n && expired;
   assign wdog_clear = (state_q != PB_STROBE);
   assign wdog_tick  = (state_q == PB_STROBE) && rdy_n;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         PB_IDLE:   if (accept) state_d = PB_SETUP;
         PB_SETUP:  state_d = PB_STROBE;
         PB_STROBE: if (finish_ok || finish_to) state_d = PB_IDLE;
         default:   state_d = PB_IDLE;
      endcase
   end

   assign strobe_next = (state_d == PB_STROBE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= PB_IDLE;
         en_n_q  <= 1'b1;
         done_q  <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         en_n_q  <= !strobe_next;
         done_q  <= finish_ok || finish_to;
         err_q   <= finish_to;
      end
   end
endmodule

// File: rtl/pbus_datapath.sv
module pbus_datapath #(
   parameter int ADDR_W = 3,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic              strobe_next,
   input  logic              finish_ok,
   input  logic [DATA_W-1:0] pb_din,
   output logic [ADDR_W-1:0] addr_q,
   output logic              rd_wn_q,
   output logic [DATA_W-1:0] dout_q,
   output logic              oe_q,
   output logic [DATA_W-1:0] rdata_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q  <= '0;
         rd_wn_q <= 1'b1;
         dout_q  <= '0;
      end else if (accept) begin
         addr_q  <= req_addr;
         rd_wn_q <= !req_write;
         dout_q  <= req_wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         oe_q <= 1'b0;
      end else begin
         oe_q <= strobe_next && !rd_wn_q;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata_q <= '0;
      end else if (finish_ok && rd_wn_q) begin
         rdata_q <= pb_din;
      end
   end
endmodule

// File: rtl/pbus_master.sv
module pbus_master
   import pbus_pkg::*;
#(
   parameter int ADDR_W         = 3,
   parameter int DATA_W         = 16,
   parameter int TIMEOUT_CYCLES = 256
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rsp_done,
   output logic              rsp_err,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              busy,
   output logic [ADDR_W-1:0] pb_addr,
   output logic              pb_rd_wn,
   output logic              pb_en_n,
   input  logic              pb_rdy_n,
   output logic [DATA_W-1:0] pb_dout,
   output logic              pb_dout_oe,
   input  logic [DATA_W-1:0] pb_din
);
   initial begin
      if (ADDR_W < 1 || ADDR_W > 16) $fatal(1, "pbus_master: ADDR_W out of range");
      if (DATA_W < 1)                $fatal(1, "pbus_master: DATA_W out of range");
      if (TIMEOUT_CYCLES < 0)        $fatal(1, "pbus_master: TIMEOUT_CYCLES negative");
   end

   pb_state_e state_q;
   logic      accept, finish_ok, strobe_next;
   logic      wdog_clear, wdog_tick, expired;

   pbus_seq u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_valid   (req_valid),
      .rdy_n       (pb_rdy_n),
      .expired     (expired),
      .state_q     (state_q),
      .accept      (accept),
      .finish_ok   (finish_ok),
      .strobe_next (strobe_next),
      .wdog_clear  (wdog_clear),
      .wdog_tick   (wdog_tick),
      .en_n_q      (pb_en_n),
      .done_q      (rsp_done),
      .err_q       (rsp_err)
   );

   pbus_wdog #(.LIMIT(TIMEOUT_CYCLES)) u_wdog (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (wdog_clear),
      .tick    (wdog_tick),
      .expired (expired)
   );

   pbus_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
      .clk         (clk),
      .rst_n       (rst_n),
      .accept      (accept),
      .req_write   (req_write),
      .req_addr    (req_addr),
      .req_wdata   (req_wdata),
      .strobe_next (strobe_next),
      .finish_ok   (finish_ok),
      .pb_din      (pb_din),
      .addr_q      (pb_addr),
      .rd_wn_q     (pb_rd_wn),
      .dout_q      (pb_dout),
      .oe_q        (pb_dout_oe),
      .rdata_q     (rsp_rdata)
   );

   assign busy = (state_q != PB_IDLE);
endmodule

// File: rtl/pbus_master_chk.sv
module pbus_master_chk #(
   parameter int ADDR_W         = 3,
   parameter int TIMEOUT_CYCLES = 256
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy,
   input logic              rsp_done,
   input logic              rsp_err,
   input logic [ADDR_W-1:0] pb_addr,
   input logic              pb_rd_wn,
   input logic              pb_en_n,
   input logic              pb_dout_oe
);
   int unsigned low_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) low_cnt <= 0;
      else if (!pb_en_n) low_cnt <= low_cnt + 1;
      else low_cnt <= 0;
   end

   AST_SETUP_BEFORE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pb_en_n) |-> $past(busy)); // R2
   AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      !pb_en_n |=> ($stable(pb_addr) && $stable(pb_rd_wn))); // R3
   AST_OE_IN_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      pb_dout_oe |-> (!pb_en_n && !pb_rd_wn)); // R5
   AST_DONE_ENDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |-> ($rose(pb_en_n) && !busy)); // R6
   AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |=> !rsp_done); // R7
   AST_ERR_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_err |-> rsp_done); // R10
   AST_STROBE_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
      (TIMEOUT_CYCLES == 0) || (low_cnt <= TIMEOUT_CYCLES)); // R9
endmodule

bind pbus_master pbus_master_chk #(.ADDR_W(ADDR_W), .TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .busy       (busy),
   .rsp_done   (rsp_done),
   .rsp_err    (rsp_err),
   .pb_addr    (pb_addr),
   .pb_rd_wn   (pb_rd_wn),
   .pb_en_n    (pb_en_n),
   .pb_dout_oe (pb_dout_oe)
);

// File: tb/sim_pbus_master.sv
`timescale 1ns/1ps
module sim_pbus_master;
   localparam int AW = 3;
   localparam int DW = 16;
   localparam int TO = 256;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_write = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic          rsp_done, rsp_err, busy;
   logic [DW-1:0] rsp_rdata;
   logic [AW-1:0] pb_addr;
   logic          pb_rd_wn, pb_en_n, pb_dout_oe;
   logic          pb_rdy_n = 1'b1;
   logic [DW-1:0] pb_dout, pb_din;

   always #2.5 clk = ~clk;

   pbus_master #(.ADDR_W(AW), .DATA_W(DW), .TIMEOUT_CYCLES(TO)) u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .rsp_done(rsp_done),
      .rsp_err(rsp_err), .rsp_rdata(rsp_rdata), .busy(busy), .pb_addr(pb_addr),
      .pb_rd_wn(pb_rd_wn), .pb_en_n(pb_en_n), .pb_rdy_n(pb_rdy_n),
      .pb_dout(pb_dout), .pb_dout_oe(pb_dout_oe), .pb_din(pb_din)
   );

   // peripheral model
   logic [DW-1:0] periph [8];
   logic [DW-1:0] shadow [8];
   int            pwait = 0;
   int            scnt  = 0;

   assign pb_din = (!pb_en_n && pb_rd_wn) ? periph[pb_addr] : 16'hDEAD;

   always @(negedge clk) begin
      if (!pb_en_n) begin
         pb_rdy_n <= (scnt >= pwait) ? 1'b0 : 1'b1;
         scnt     <= scnt + 1;
      end else begin
         pb_rdy_n <= 1'b1;
         scnt     <= 0;
      end
   end

   always @(posedge clk) begin
      if (!pb_en_n && !pb_rdy_n && !pb_rd_wn)
         periph[pb_addr] <= pb_dout_oe ? pb_dout : 16'h0BAD;
   end

   int            checks = 0;
   int            failures = 0;
   logic [DW-1:0] last_rd = '0;
   bit            finished = 1'b0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   // one access; inject=1 raises a store to addr 1 during the strobe
   task automatic access(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                         input int w, input int exp_len, input bit exp_err, input bit inject);
      int  len = 0;
      bit  got_done = 1'b0;
      pwait = w;
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      chk(busy && pb_en_n, "R2 setup cycle", {busy, pb_en_n}, 2'b11);
      chk(pb_addr == a, "R2 address presented", pb_addr, a);
      chk(pb_rd_wn == !wr, "R4 direction line", pb_rd_wn, !wr);
      for (int i = 0; i < 400 && !got_done; i++) begin
         @(negedge clk);
         if (inject && len == 2) begin
            req_valid = 1'b1; req_write = 1'b1; req_addr = 3'd1; req_wdata = 16'hBEEF;
         end else if (inject) begin
            req_valid = 1'b0;
         end
         if (rsp_done) begin
            got_done = 1'b1;
         end else begin
            if (!pb_en_n) len++;
            if (!pb_en_n && (pb_dout_oe !== wr)) chk(0, "R5 drive enable in strobe", pb_dout_oe, wr);
            if (!pb_en_n && (pb_addr !== a))    chk(0, "R3 address stable", pb_addr, a);
            if (!pb_en_n && wr && pb_dout !== d) chk(0, "R5 store data", pb_dout, d);
         end
      end
      req_valid = 1'b0;
      chk(got_done, "R7 done seen", got_done, 1);
      chk(len == exp_len, (exp_err ? "R9 strobe length at timeout" : "R6 strobe length"), len, exp_len);
      chk(pb_en_n && !pb_dout_oe && !busy, "R7 bus released at done", {pb_en_n, pb_dout_oe, busy}, 3'b100);
      chk(pb_addr == a && pb_rd_wn == !wr, "R3 address held as strobe rises", pb_addr, a);
      chk(rsp_err == exp_err, (exp_err ? "R9 error flag" : "R10 no error"), rsp_err, exp_err);
      if (!wr && !exp_err) last_rd = shadow[a];
      if (wr && !exp_err) shadow[a] = d;
      chk(rsp_rdata == last_rd, (wr ? "R7 rdata held over store" : (exp_err ? "R9 rdata kept" : "R7 load data")),
          rsp_rdata, last_rd);
      @(negedge clk);
      chk(!rsp_done, "R7 done is one cycle", rsp_done, 0);
   endtask

   // {wr, addr, data, wait}
   localparam int NV = 10;
   localparam logic [23:0] VEC [NV] = '{
      {1'b1, 3'd2, 16'hA5A5, 4'd0},
      {1'b0, 3'd2, 16'h0000, 4'd0},
      {1'b1, 3'd7, 16'h1234, 4'd3},
      {1'b0, 3'd7, 16'h0000, 4'd2},
      {1'b1, 3'd0, 16'hFFFF, 4'd1},
      {1'b0, 3'd0, 16'h0000, 4'd5},
      {1'b0, 3'd3, 16'h0000, 4'd0},
      {1'b1, 3'd5, 16'h0001, 4'd7},
      {1'b0, 3'd5, 16'h0000, 4'd0},
      {1'b0, 3'd2, 16'h0000, 4'd9}
   };

   initial begin
      for (int i = 0; i < 8; i++) begin
         periph[i] = 16'h1000 + 16'(i) * 16'h0111;
         shadow[i] = periph[i];
      end
      repeat (3) @(negedge clk);
      chk(pb_en_n && !pb_dout_oe && !rsp_done && !rsp_err && !busy, "R1 reset outputs",
          {pb_en_n, pb_dout_oe, rsp_done, rsp_err, busy}, 5'b10000);
      rst_n = 1'b1;
      @(negedge clk);
      chk(rsp_rdata == 16'h0 && pb_en_n, "R1 state after reset", rsp_rdata, 0);

      for (int v = 0; v < NV; v++) begin
         access(VEC[v][23], VEC[v][22:20], VEC[v][19:4], int'(VEC[v][3:0]),
                int'(VEC[v][3:0]) + 1, 1'b0, 1'b0);
      end

      // R8: store raised mid-load is dropped
      access(1'b0, 3'd4, 16'h0, 4, 5, 1'b0, 1'b1);
      begin
         bit quiet = 1'b1;
         for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            if (!pb_en_n || busy) quiet = 1'b0;
         end
         chk(quiet, "R8 no access after dropped request", quiet, 1);
      end
      access(1'b0, 3'd1, 16'h0, 0, 1, 1'b0, 1'b0);
      chk(rsp_rdata == 16'h1111, "R8 dropped store left register", rsp_rdata, 16'h1111);

      // R9: peripheral never ready
      access(1'b0, 3'd6, 16'h0, 100000, TO, 1'b1, 1'b0);

      // R1: reset in the middle of a store strobe
      pwait = 1000;
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b1; req_addr = 3'd3; req_wdata = 16'h7777;
      @(negedge clk);
      req_valid = 1'b0;
      repeat (2) @(negedge clk);
      chk(!pb_en_n && pb_dout_oe, "R5 store strobe driving", {pb_en_n, pb_dout_oe}, 2'b01);
      rst_n = 1'b0;
      @(negedge clk);
      chk(pb_en_n && !pb_dout_oe && !busy, "R1 reset mid-access", {pb_en_n, pb_dout_oe, busy}, 3'b100);
      rst_n = 1'b1;
      @(negedge clk);
      access(1'b0, 3'd3, 16'h0, 1, 2, 1'b0, 1'b0);

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         failures++;
         $display("FAIL watchdog: run did not finish actual=0 expected=1");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule